// File: doc/BRIEF.md
# Handshaked Character Terminal Port

This block sits between a host and a terminal-side byte stream and paces both directions with handshake lines whose edges move only after counted delays. A host hands a byte to the port by placing it on a data bus and raising a send strobe while the port shows its ready flag. The byte is held for a full character time. At the end of that time it leaves on the terminal side as a one-cycle valid pulse, and after a short recovery the ready flag returns.

In the other direction, a terminal-side source offers a byte with a valid/ready pair. The port spends a character time "reading" it, and after a further delay it raises a request flag with the byte on its output bus. The host reads the bus and raises its acknowledge. A set delay later the request drops and the port accepts the next byte.

All timing is counted in ticks of a base enable input, and every delay is a parameter. Each delay runs on a down-counter that only moves on a tick.

Top module: `term_port`

## Requirements
- R1: Out of reset, host_tx_ready and line_rx_ready are 1, host_rx_req and line_tx_valid are 0, and host_rx_data is all zeros.
- R2: A transmit transfer starts on a clock edge where host_tx_send is sampled 1, was sampled 0 on the previous edge, and the channel is idle. host_tx_data is captured on that edge, and later changes to it have no effect on the byte sent. The previous-strobe register resets to 1, so a strobe held high through reset does not start a transfer.
- R3: A rising send strobe that arrives while a transfer is in progress is ignored, including one that arrives while host_tx_ready is low. Exactly one line_tx_valid pulse results per accepted transfer.
- R4: host_tx_ready falls TX_RDY_FALL ticks after the accepting edge (default 8, which must be less than TX_CHAR_TICKS).
- R5: line_tx_valid is a single-cycle pulse, high TX_CHAR_TICKS ticks after the accepting edge (default 150). It carries the captured byte on line_tx_data.
- R6: host_tx_ready rises TX_RDY_RISE ticks after the line_tx_valid pulse is issued (default 2).
- R7: A send strobe held high across the end of a transfer starts nothing further until it is lowered and raised again.
- R8: A terminal-side byte is taken on an edge where line_rx_valid and line_rx_ready are both 1. line_rx_ready is low from the next cycle until host_rx_req has fallen, and it is never high while host_rx_req is high.
- R9: host_rx_req rises RX_CHAR_TICKS + RX_REQ_RISE ticks after the byte is taken (defaults 150 and 2). host_rx_data then shows the taken byte, and later changes on line_rx_data have no effect on it.
- R10: host_rx_data changes only on the edge where host_rx_req rises. It stays stable while the request is high and keeps its value after the request falls.
- R11: host_rx_req falls RX_REQ_FALL ticks (default 2) after the first edge on which host_rx_ack is sampled 1 while the request is high. line_rx_ready rises on the same edge.
- R12: On an edge where tick is 0, no delay counter advances: host_tx_ready, host_rx_req and line_tx_valid keep their values and every pending event moves later by one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Base time enable; delay counters move only when 1 |
| host_tx_data | input | DATA_W | Byte the host wants to send |
| host_tx_send | input | 1 | Send strobe, acted on at its rising edge |
| host_tx_ready | output | 1 | Port can accept a byte from the host |
| line_tx_data | output | DATA_W | Byte delivered to the terminal side |
| line_tx_valid | output | 1 | One-cycle pulse marking line_tx_data |
| line_rx_data | input | DATA_W | Byte from the terminal-side source |
| line_rx_valid | input | 1 | Terminal-side byte is present |
| line_rx_ready | output | 1 | Port can take a terminal-side byte |
| host_rx_data | output | DATA_W | Received byte offered to the host |
| host_rx_req | output | 1 | Request flag: host_rx_data holds a new byte |
| host_rx_ack | input | 1 | Host acknowledge of the offered byte |

## Verification
The assertions check several rules on every cycle: the valid pulse lasts one cycle, ready is low when a byte leaves, the receive data bus changes only when the request rises, line_rx_ready and host_rx_req are never high together, taking a byte drops line_rx_ready, and an edge without a tick freezes the counted outputs. The exact tick counts between handshake edges are shown only by the bench's scenarios. These cover full byte sweeps in both directions, strobes ignored mid-transfer, a strobe held high, an early acknowledge and stretches of missing ticks, with each expected edge position computed from the delay parameters.

// File: rtl/term_pkg.sv
package term_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_BUSY  = 2'd1,
    TX_RECOV = 2'd2
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE = 3'd0,
    RX_READ = 3'd1,
    RX_REQW = 3'd2,
    RX_HELD = 3'd3,
    RX_DROP = 3'd4
  } rx_state_e;

  function automatic int max_of3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/delay_ctr.sv
module delay_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;

  // fires on the tick that takes the count from one to zero
  assign expire = tick && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick && (cnt != '0)) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/tx_chan.sv
module tx_chan
  import term_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CHAR_TICKS = 150,
  parameter int RDY_FALL   = 8,
  parameter int RDY_RISE   = 2,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_send,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);

  tx_state_e         state;
  logic              send_q;
  logic [DATA_W-1:0] hold;
  logic              accept;
  logic              char_exp;
  logic              edge_exp;
  logic              edge_load;
  logic [CNT_W-1:0]  edge_val;

  assign accept    = (state == TX_IDLE) && in_send && !send_q;
  assign edge_load = accept || ((state == TX_BUSY) && char_exp);
  assign edge_val  = accept ? CNT_W'(RDY_FALL) : CNT_W'(RDY_RISE);

  delay_ctr #(.CNT_W(CNT_W)) u_char (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (accept),
    .load_val (CNT_W'(CHAR_TICKS)),
    .expire   (char_exp)
  );

  delay_ctr #(.CNT_W(CNT_W)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (edge_load),
    .load_val (edge_val),
    .expire   (edge_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= TX_IDLE;
      send_q    <= 1'b1;
      hold      <= '0;
      in_ready  <= 1'b1;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      send_q    <= in_send;
      out_valid <= 1'b0;
      unique case (state)
        TX_IDLE: begin
          if (accept) begin
            hold  <= in_data;
            state <= TX_BUSY;
          end
        end
        TX_BUSY: begin
          if (edge_exp) in_ready <= 1'b0;
          if (char_exp) begin
            out_data  <= hold;
            out_valid <= 1'b1;
            in_ready  <= 1'b0;
            state     <= TX_RECOV;
          end
        end
        TX_RECOV: begin
          if (edge_exp) begin
            in_ready <= 1'b1;
            state    <= TX_IDLE;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_chan.sv
module rx_chan
  import term_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CHAR_TICKS = 150,
  parameter int REQ_RISE   = 2,
  parameter int REQ_FALL   = 2,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_valid,
  output logic              src_ready,
  output logic [DATA_W-1:0] dst_data,
  output logic              dst_req,
  input  logic              dst_ack
);

  rx_state_e         state;
  logic [DATA_W-1:0] buf_q;
  logic              accept;
  logic              take_ack;
  logic              expire;
  logic              load;
  logic [CNT_W-1:0]  load_val;

  assign accept   = (state == RX_IDLE) && src_valid;
  assign take_ack = (state == RX_HELD) && dst_ack;

  always_comb begin
    load     = 1'b0;
    load_val = CNT_W'(CHAR_TICKS);
    if (accept) begin
      load     = 1'b1;
      load_val = CNT_W'(CHAR_TICKS);
    end else if ((state == RX_READ) && expire) begin
      load     = 1'b1;
      load_val = CNT_W'(REQ_RISE);
    end else if (take_ack) begin
      load     = 1'b1;
      load_val = CNT_W'(REQ_FALL);
    end
  end

  delay_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (load),
    .load_val (load_val),
    .expire   (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      buf_q     <= '0;
      src_ready <= 1'b1;
      dst_data  <= '0;
      dst_req   <= 1'b0;
    end else begin
      unique case (state)
        RX_IDLE: begin
          if (accept) begin
            buf_q     <= src_data;
            src_ready <= 1'b0;
            state     <= RX_READ;
          end
        end
        RX_READ: begin
          if (expire) state <= RX_REQW;
        end
        RX_REQW: begin
          if (expire) begin
            dst_req  <= 1'b1;
            dst_data <= buf_q;
            state    <= RX_HELD;
          end
        end
        RX_HELD: begin
          if (take_ack) state <= RX_DROP;
        end
        RX_DROP: begin
          if (expire) begin
            dst_req   <= 1'b0;
            src_ready <= 1'b1;
            state     <= RX_IDLE;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/term_port.sv
module term_port
  import term_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TX_CHAR_TICKS = 150,
  parameter int TX_RDY_FALL   = 8,
  parameter int TX_RDY_RISE   = 2,
  parameter int RX_CHAR_TICKS = 150,
  parameter int RX_REQ_RISE   = 2,
  parameter int RX_REQ_FALL   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [DATA_W-1:0] host_tx_data,
  input  logic              host_tx_send,
  output logic              host_tx_ready,
  output logic [DATA_W-1:0] line_tx_data,
  output logic              line_tx_valid,
  input  logic [DATA_W-1:0] line_rx_data,
  input  logic              line_rx_valid,
  output logic              line_rx_ready,
  output logic [DATA_W-1:0] host_rx_data,
  output logic              host_rx_req,
  input  logic              host_rx_ack
);

  localparam int TX_MAX  = max_of3(TX_CHAR_TICKS, TX_RDY_FALL, TX_RDY_RISE);
  localparam int RX_MAX  = max_of3(RX_CHAR_TICKS, RX_REQ_RISE, RX_REQ_FALL);
  localparam int TX_CW   = $clog2(TX_MAX + 1);
  localparam int RX_CW   = $clog2(RX_MAX + 1);

  tx_chan #(
    .DATA_W     (DATA_W),
    .CHAR_TICKS (TX_CHAR_TICKS),
    .RDY_FALL   (TX_RDY_FALL),
    .RDY_RISE   (TX_RDY_RISE),
    .CNT_W      (TX_CW)
  ) u_tx (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .in_data   (host_tx_data),
    .in_send   (host_tx_send),
    .in_ready  (host_tx_ready),
    .out_data  (line_tx_data),
    .out_valid (line_tx_valid)
  );

  rx_chan #(
    .DATA_W     (DATA_W),
    .CHAR_TICKS (RX_CHAR_TICKS),
    .REQ_RISE   (RX_REQ_RISE),
    .REQ_FALL   (RX_REQ_FALL),
    .CNT_W      (RX_CW)
  ) u_rx (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .src_data  (line_rx_data),
    .src_valid (line_rx_valid),
    .src_ready (line_rx_ready),
    .dst_data  (host_rx_data),
    .dst_req   (host_rx_req),
    .dst_ack   (host_rx_ack)
  );

endmodule

// File: rtl/term_port_chk.sv
module term_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [DATA_W-1:0] host_tx_data,
  input logic              host_tx_send,
  input logic              host_tx_ready,
  input logic [DATA_W-1:0] line_tx_data,
  input logic              line_tx_valid,
  input logic [DATA_W-1:0] line_rx_data,
  input logic              line_rx_valid,
  input logic              line_rx_ready,
  input logic [DATA_W-1:0] host_rx_data,
  input logic              host_rx_req,
  input logic              host_rx_ack
);

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    line_tx_valid |=> !line_tx_valid);

  p_busy_at_send_r3: assert property (@(posedge clk) disable iff (rst)
    line_tx_valid |-> !host_tx_ready);

  p_rx_data_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$rose(host_rx_req) |-> $stable(host_rx_data));

  p_req_excl_ready_r8: assert property (@(posedge clk) disable iff (rst)
    host_rx_req |-> !line_rx_ready);

  p_take_drops_ready_r8: assert property (@(posedge clk) disable iff (rst)
    (line_rx_valid && line_rx_ready) |=> !line_rx_ready);

  p_no_tick_freeze_r12: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(host_tx_ready) && $stable(host_rx_req) && !line_tx_valid));

endmodule

bind term_port term_port_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_term_port.sv
`timescale 1ns/1ps
module sim_term_port;

  localparam int DW  = 8;
  localparam int TXC = 7;
  localparam int TDN = 3;
  localparam int TUP = 2;
  localparam int RXC = 6;
  localparam int RUP = 2;
  localparam int RDN = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b1;
  logic [DW-1:0] host_tx_data = '0;
  logic          host_tx_send = 1'b0;
  logic          host_tx_ready;
  logic [DW-1:0] line_tx_data;
  logic          line_tx_valid;
  logic [DW-1:0] line_rx_data = '0;
  logic          line_rx_valid = 1'b0;
  logic          line_rx_ready;
  logic [DW-1:0] host_rx_data;
  logic          host_rx_req;
  logic          host_rx_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [DW-1:0] last_rx = '0;

  always #2.5 clk = ~clk;

  term_port #(
    .DATA_W(DW), .TX_CHAR_TICKS(TXC), .TX_RDY_FALL(TDN), .TX_RDY_RISE(TUP),
    .RX_CHAR_TICKS(RXC), .RX_REQ_RISE(RUP), .RX_REQ_FALL(RDN)
  ) u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0: plain, mode 1: extra strobe mid-transfer, mode 2: strobe held high
  task automatic tx_one(input logic [DW-1:0] b, input int mode, input int stall);
    int fall_s = -1;
    int rise_s = -1;
    int val_s = -1;
    int val_n = 0;
    logic [DW-1:0] val_d = '0;
    for (int g = 0; g < 50 && !host_tx_ready; g++) @(negedge clk);
    host_tx_data = b;
    host_tx_send = 1'b1;
    @(posedge clk);
    for (int s = 0; s < TXC + TUP + stall + 4; s++) begin
      @(negedge clk);
      if (!host_tx_ready && fall_s < 0) fall_s = s;
      if (fall_s >= 0 && host_tx_ready && rise_s < 0) rise_s = s;
      if (line_tx_valid) begin
        val_n++;
        if (val_s < 0) begin val_s = s; val_d = line_tx_data; end
      end
      if (s == 1) host_tx_data = ~b;
      if (s == 1 && mode != 2) host_tx_send = 1'b0;
      if (mode == 1 && s == TDN + stall + 1) host_tx_send = 1'b1;
      if (mode == 1 && s == TDN + stall + 2) host_tx_send = 1'b0;
      if (stall > 0) tick = !(s >= 1 && s <= stall);
    end
    tick = 1'b1;
    chk(fall_s == TDN + stall, (stall > 0) ? "R4/R12 ready fall" : "R4 ready fall", fall_s, TDN + stall);
    chk(val_s == TXC + stall, (stall > 0) ? "R5/R12 valid time" : "R5 valid time", val_s, TXC + stall);
    chk(val_d == b, "R2 captured byte", val_d, b);
    chk(val_n == 1, (mode == 1) ? "R3 single pulse" : "R5 single pulse", val_n, 1);
    chk(rise_s == TXC + TUP + stall, "R6 ready rise", rise_s, TXC + TUP + stall);
    if (mode == 2) begin
      int extra = 0;
      for (int s = 0; s < 6; s++) begin
        @(negedge clk);
        if (line_tx_valid || !host_tx_ready) extra++;
      end
      chk(extra == 0, "R7 held strobe idle", extra, 0);
      host_tx_send = 1'b0;
      @(negedge clk);
    end
    host_tx_send = 1'b0;
  endtask

  task automatic rx_one(input logic [DW-1:0] b, input bit early);
    int rise_s = -1;
    int fall_s = -1;
    int ack_s = -1;
    int bad_hold = 0;
    int pre_bad = 0;
    logic [DW-1:0] rise_d = '0;
    for (int g = 0; g < 50 && !line_rx_ready; g++) @(negedge clk);
    chk(line_rx_ready == 1'b1, "R8 ready before take", line_rx_ready, 1);
    line_rx_data = b;
    line_rx_valid = 1'b1;
    if (early) host_rx_ack = 1'b1;
    @(posedge clk);
    for (int s = 0; s < RXC + RUP + RDN + 10; s++) begin
      @(negedge clk);
      if (s == 0) begin
        chk(line_rx_ready == 1'b0, "R8 ready low after take", line_rx_ready, 0);
        line_rx_valid = 1'b0;
        line_rx_data = ~b;
      end
      if (host_rx_req && rise_s < 0) begin rise_s = s; rise_d = host_rx_data; end
      if (rise_s < 0 && host_rx_data != last_rx) pre_bad++;
      if (rise_s >= 0 && fall_s < 0 && !host_rx_req) begin
        fall_s = s;
        chk(line_rx_ready == 1'b1, "R11 ready with fall", line_rx_ready, 1);
      end
      if (host_rx_req && host_rx_data != b) bad_hold++;
      if (fall_s >= 0 && host_rx_data != b) bad_hold++;
      if (!early && rise_s >= 0 && s == rise_s + 2) begin
        host_rx_ack = 1'b1;
        ack_s = s;
      end
      if (early && rise_s >= 0 && ack_s < 0) ack_s = s;
    end
    host_rx_ack = 1'b0;
    chk(rise_s == RXC + RUP, "R9 request rise", rise_s, RXC + RUP);
    chk(rise_d == b, "R9 offered byte", rise_d, b);
    chk(pre_bad == 0, "R10 data before rise", pre_bad, 0);
    chk(bad_hold == 0, "R10 data hold", bad_hold, 0);
    chk(fall_s == ack_s + 1 + RDN, "R11 request fall", fall_s, ack_s + 1 + RDN);
    last_rx = b;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    host_tx_send = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(host_tx_ready == 1'b1, "R1 tx ready", host_tx_ready, 1);
    chk(line_rx_ready == 1'b1, "R1 rx ready", line_rx_ready, 1);
    chk(host_rx_req == 1'b0, "R1 req", host_rx_req, 0);
    chk(line_tx_valid == 1'b0, "R1 valid", line_tx_valid, 0);
    chk(host_rx_data == '0, "R1 rx data", host_rx_data, 0);
    // strobe held through reset must not start a transfer (R2)
    begin
      int seen = 0;
      for (int s = 0; s < TXC + 4; s++) begin
        @(negedge clk);
        if (line_tx_valid || !host_tx_ready) seen++;
      end
      chk(seen == 0, "R2 no start from reset strobe", seen, 0);
    end
    host_tx_send = 1'b0;
    @(negedge clk);

    for (int v = 0; v < 256; v++) tx_one(DW'(v), 0, 0);
    tx_one(8'h5A, 1, 0);
    tx_one(8'hC3, 1, 2);
    tx_one(8'h81, 2, 0);
    tx_one(8'h3C, 0, 4);
    tx_one(8'hE7, 0, 1);

    for (int v = 0; v < 256; v++) rx_one(DW'(255 - v), 1'b0);
    rx_one(8'h96, 1'b1);
    rx_one(8'h69, 1'b1);
    rx_one(8'h00, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule